// File: doc/BRIEF.md
# Four-Queue Shared-Memory FIFO with Addressed Queue Selection

This block carves one storage array into four equal logical FIFO queues. A producer and a consumer, both on the same clock, each pick the queue they work on by presenting an address together with a select strobe; the choice is held until the next strobe. Writes go into the producer's current queue. Reads come out of the consumer's current queue into a registered output word.

Both selection addresses carry three fields: a queue index, a null-queue bit that parks the port on no queue at all, and a device identifier. Several copies of the block can share one pair of address buses, each built with its own identifier. A strobe whose identifier differs from the block's own releases the port, so only one device owns a port at a time. Status flags (empty and active-low almost-empty for the consumer's queue, full and active-low almost-full for the producer's queue) always describe the queues that are currently selected. A partial reset empties a single queue whose selection has stayed unchanged on both ports. Selection strobes are ignored until a programming-done input is high.

Top module: `mq_fifo`

## Requirements
- R1: While reset is held and right after it, neither port owns a queue, and the outputs read empty=1, full=1, almost_empty_n=0, almost_full_n=0 and rd_data=0.
- R2: A port's selection changes only on a clock edge where its select strobe is high and prog_done is high. A strobe while prog_done is low leaves the selection unchanged.
- R3: A selection address is decoded as bits [1:0] = queue index, bit [2] = null-queue bit, bits [5:3] = device identifier. The selection is taken only when bits [5:3] equal the DEV_ID parameter (default 5). A strobe with any other identifier leaves the port owning no queue.
- R4: On an edge with wr_en high, where the write port owns a real queue that is not full, wr_data is appended to that queue. Each queue returns its words in the order they were written, independent of traffic on other queues.
- R5: On an edge with rd_en high, oe_n low and the read port owning a real non-empty queue, the oldest word of that queue is removed and appears on rd_data after that edge. rd_data holds its value on every edge without such a read.
- R6: A port that owns no queue, or that has the null queue selected, changes no queue's contents when wr_en or rd_en is high.
- R7: A write to a full queue (DEPTH words, default 16) is dropped. A read from an empty queue is dropped, and rd_data keeps its value.
- R8: empty and almost_empty_n describe the read-selected queue, and full and almost_full_n describe the write-selected queue. almost_empty_n is low when the count is at or below that queue's AE level (defaults 2,3,4,5 for queues 0..3). almost_full_n is low when the count is at or above DEPTH minus that queue's AF level (defaults 5,4,3,2). A port without a real queue shows the values of R1.
- R9: When prs_n is low on an edge, both ports own the same real queue, and neither port's selection has been strobed in the two preceding edges, that queue is emptied. Any read or write to it on that edge is dropped, and the other queues keep their contents.
- R10: prs_n low under any other condition has no effect on any queue.
- R11: Pointers wrap inside each queue's own region, so FIFO order and the contents of the other queues stay correct after more than DEPTH writes to one queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_done | input | 1 | High once initial programming is finished; enables selection strobes |
| wr_sel | input | 1 | Write-port select strobe |
| wr_addr | input | 6 | Write-port selection address (device id, null bit, queue index) |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to write |
| rd_sel | input | 1 | Read-port select strobe |
| rd_addr | input | 6 | Read-port selection address (device id, null bit, queue index) |
| rd_en | input | 1 | Read request |
| oe_n | input | 1 | Active-low output enable; a read needs it low |
| prs_n | input | 1 | Active-low partial reset of the jointly selected queue |
| rd_data | output | DW | Registered read word |
| empty | output | 1 | Read-selected queue holds no words |
| almost_empty_n | output | 1 | Active-low almost-empty of the read-selected queue |
| full | output | 1 | Write-selected queue holds DEPTH words |
| almost_full_n | output | 1 | Active-low almost-full of the write-selected queue |

## Verification
A pointer or count that goes wrong inside one queue shows at the ports only once that queue is selected again. It then appears as a flag that differs from the occupancy implied by the traffic, or as a read word that differs from the expected FIFO order. A wrong selection register shows up one edge after the strobe through the flags, because all four flags follow the selected queues. The bench therefore switches queues often and reads every queue back to empty, so that corrupted state in an idle queue is still reached within a few hundred cycles.

// File: rtl/mq_pkg.sv
package mq_pkg;
    localparam int NQ  = 4;   // logical queues
    localparam int QW  = 2;   // queue index width
    localparam int IDW = 3;   // device identifier width
    localparam int AW  = QW + 1 + IDW; // selection address width

    typedef struct packed {
        logic          own;   // this device owns the port
        logic          nul;   // null queue parked
        logic [QW-1:0] q;     // queue index
    } sel_t;
endpackage

// File: rtl/mq_sel.sv
module mq_sel
    import mq_pkg::*;
#(
    parameter logic [IDW-1:0] DEV_ID = 3'd5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_done,
    input  logic          sel_en,
    input  logic [AW-1:0] addr,
    output sel_t          sel_o,
    output logic          chg_o
);
    sel_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        chg_o = 1'b0;
        if (sel_en && prog_done) begin
            chg_o = 1'b1;
            if (addr[AW-1 -: IDW] == DEV_ID) begin
                s_d.own = 1'b1;
                s_d.nul = addr[QW];
                s_d.q   = addr[QW-1:0];
            end else begin
                s_d.own = 1'b0;
                s_d.nul = 1'b0;
                s_d.q   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sel_o = s_q;
endmodule

// File: rtl/mq_qctrl.sv
module mq_qctrl #(
    parameter int DEPTH = 16,
    parameter int AE    = 2,
    parameter int AF    = 2,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          clr,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output logic [CW-1:0] cnt,
    output logic          empty,
    output logic          full,
    output logic          ae_n,
    output logic          af_n
);
    localparam logic [PW-1:0] LAST   = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] AE_C   = CW'(AE);
    localparam logic [CW-1:0] AF_C   = CW'(DEPTH - AF);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            if (push) s_d.wp = (s_q.wp == LAST) ? '0 : s_q.wp + 1'b1;
            if (pop)  s_d.rp = (s_q.rp == LAST) ? '0 : s_q.rp + 1'b1;
            if (push && !pop)      s_d.cnt = s_q.cnt + 1'b1;
            else if (pop && !push) s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wptr  = s_q.wp;
    assign rptr  = s_q.rp;
    assign cnt   = s_q.cnt;
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == FULL_C);
    assign ae_n  = (s_q.cnt > AE_C);
    assign af_n  = (s_q.cnt < AF_C);
endmodule

// File: rtl/mq_mem.sv
module mq_mem #(
    parameter int DW   = 18,
    parameter int MAW  = 6,
    localparam int NW  = 1 << MAW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [MAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic           re,
    input  logic [MAW-1:0] raddr,
    output logic [DW-1:0]  rdata
);
    logic [DW-1:0] mem [NW];
    logic [DW-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb begin
        rd_d = rd_q;
        if (re) rd_d = mem[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q;
endmodule

// File: rtl/mq_fifo.sv
module mq_fifo
    import mq_pkg::*;
#(
    parameter int DW                = 18,
    parameter int DEPTH             = 16,
    parameter logic [IDW-1:0] DEV_ID = 3'd5,
    parameter logic [NQ*8-1:0] AE_LVL = {8'd5, 8'd4, 8'd3, 8'd2},
    parameter logic [NQ*8-1:0] AF_LVL = {8'd2, 8'd3, 8'd4, 8'd5},
    localparam int CW  = $clog2(DEPTH + 1),
    localparam int PW  = $clog2(DEPTH),
    localparam int MAW = QW + PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_done,
    input  logic          wr_sel,
    input  logic [5:0]    wr_addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_sel,
    input  logic [5:0]    rd_addr,
    input  logic          rd_en,
    input  logic          oe_n,
    input  logic          prs_n,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          almost_empty_n,
    output logic          full,
    output logic          almost_full_n
);
    sel_t wsel, rsel;
    logic wchg, rchg;

    mq_sel #(.DEV_ID(DEV_ID)) u_wsel (
        .clk(clk), .rst_n(rst_n), .prog_done(prog_done),
        .sel_en(wr_sel), .addr(wr_addr), .sel_o(wsel), .chg_o(wchg)
    );

    mq_sel #(.DEV_ID(DEV_ID)) u_rsel (
        .clk(clk), .rst_n(rst_n), .prog_done(prog_done),
        .sel_en(rd_sel), .addr(rd_addr), .sel_o(rsel), .chg_o(rchg)
    );

    // selection age: edges since the last strobe on either port, saturating at 2
    typedef struct packed {
        logic [1:0] age;
    } st_t;
    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wchg || rchg)        s_d.age = 2'd0;
        else if (s_q.age != 2'd2) s_d.age = s_q.age + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic wreal, rreal, prs_ok, wr_fire, rd_fire;
    logic          q_empty [NQ];
    logic          q_full  [NQ];
    logic          q_ae_n  [NQ];
    logic          q_af_n  [NQ];
    logic [PW-1:0] q_wp    [NQ];
    logic [PW-1:0] q_rp    [NQ];
    logic [CW-1:0] q_cnt   [NQ];
    logic [NQ*CW-1:0] cnt_all;

    assign wreal  = wsel.own && !wsel.nul;
    assign rreal  = rsel.own && !rsel.nul;
    assign prs_ok = !prs_n && wreal && rreal && (wsel.q == rsel.q) && (s_q.age == 2'd2);
    assign wr_fire = wr_en && wreal && !q_full[wsel.q] && !prs_ok;
    assign rd_fire = rd_en && !oe_n && rreal && !q_empty[rsel.q] && !prs_ok;

    for (genvar i = 0; i < NQ; i++) begin : g_q
        mq_qctrl #(
            .DEPTH(DEPTH),
            .AE(int'(AE_LVL[i*8 +: 8])),
            .AF(int'(AF_LVL[i*8 +: 8]))
        ) u_qc (
            .clk(clk), .rst_n(rst_n),
            .push(wr_fire && (wsel.q == QW'(i))),
            .pop(rd_fire && (rsel.q == QW'(i))),
            .clr(prs_ok && (rsel.q == QW'(i))),
            .wptr(q_wp[i]), .rptr(q_rp[i]), .cnt(q_cnt[i]),
            .empty(q_empty[i]), .full(q_full[i]),
            .ae_n(q_ae_n[i]), .af_n(q_af_n[i])
        );
        assign cnt_all[i*CW +: CW] = q_cnt[i];
    end

    mq_mem #(.DW(DW), .MAW(MAW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we(wr_fire), .waddr({wsel.q, q_wp[wsel.q]}), .wdata(wr_data),
        .re(rd_fire), .raddr({rsel.q, q_rp[rsel.q]}), .rdata(rd_data)
    );

    assign empty          = rreal ? q_empty[rsel.q] : 1'b1;
    assign almost_empty_n = rreal ? q_ae_n[rsel.q]  : 1'b0;
    assign full           = wreal ? q_full[wsel.q]  : 1'b1;
    assign almost_full_n  = wreal ? q_af_n[wsel.q]  : 1'b0;
endmodule

// File: rtl/mq_fifo_chk.sv
module mq_fifo_chk #(
    parameter int DW    = 18,
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prog_done,
    input logic          rd_en,
    input logic          oe_n,
    input logic [DW-1:0] rd_data,
    input logic          empty,
    input logic          almost_empty_n,
    input logic          full,
    input logic          almost_full_n,
    input logic [3:0]    wsel_v,
    input logic [3:0]    rsel_v,
    input logic          prs_ok,
    input logic [4*CW-1:0] cnt_all
);
    logic [1:0] prs_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prs_q <= '0;
        else        prs_q <= rsel_v[1:0];
    end

    assert_empty_ae_R8: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !almost_empty_n);

    assert_full_af_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !almost_full_n);

    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !oe_n) |=> $stable(rd_data));

    assert_wsel_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_done |=> $stable(wsel_v));

    assert_rsel_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_done |=> $stable(rsel_v));

    assert_prs_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prs_ok |=> (cnt_all[int'(prs_q)*CW +: CW] == '0));

    always_comb begin
        if (rst_n) begin
            for (int i = 0; i < 4; i++) begin
                assert_no_overflow_R7: assert (int'(cnt_all[i*CW +: CW]) <= DEPTH);
            end
        end
    end
endmodule

bind mq_fifo mq_fifo_chk #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_done(prog_done),
    .rd_en(rd_en), .oe_n(oe_n), .rd_data(rd_data),
    .empty(empty), .almost_empty_n(almost_empty_n),
    .full(full), .almost_full_n(almost_full_n),
    .wsel_v(wsel), .rsel_v(rsel), .prs_ok(prs_ok), .cnt_all(cnt_all)
);

// File: tb/sim_mq_fifo.sv
`timescale 1ns/1ps
module sim_mq_fifo;
    localparam int DW = 18;
    localparam int DEPTH = 16;
    localparam int DEV = 5;
    localparam int NCYC = 6000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_done = 1'b0;
    logic wr_sel = 1'b0, rd_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic oe_n = 1'b0, prs_n = 1'b1;
    logic [5:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic empty, almost_empty_n, full, almost_full_n;

    always #4 clk = ~clk;

    mq_fifo u0 (
        .clk(clk), .rst_n(rst_n), .prog_done(prog_done),
        .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_en(rd_en), .oe_n(oe_n),
        .prs_n(prs_n), .rd_data(rd_data), .empty(empty),
        .almost_empty_n(almost_empty_n), .full(full), .almost_full_n(almost_full_n)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    // reference model state
    int mq [4][$];
    int wr_tot [4];
    int wown = 0, wnul = 0, wq = 0, rown = 0, rnul = 0, rq = 0, age = 0;
    int exp_rd = 0;
    int ae_lvl [4] = '{2, 3, 4, 5};
    int af_lvl [4] = '{5, 4, 3, 2};
    string tag = "R1";

    task automatic chk(input string t, input string nm, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, nm, act, exp, $time);
        end
    endtask

    task automatic compare();
        int rr, wr;
        rr = rown && !rnul;
        wr = wown && !wnul;
        chk(tag, "empty",          int'(empty),          rr ? int'(mq[rq].size() == 0) : 1);
        chk(tag, "almost_empty_n", int'(almost_empty_n), rr ? int'(mq[rq].size() > ae_lvl[rq]) : 0);
        chk(tag, "full",           int'(full),           wr ? int'(mq[wq].size() == DEPTH) : 1);
        chk(tag, "almost_full_n",  int'(almost_full_n),  wr ? int'(mq[wq].size() < DEPTH - af_lvl[wq]) : 0);
        chk(tag, "rd_data",        int'(rd_data),        exp_rd);
    endtask

    function automatic logic [5:0] gen_addr(input int phase);
        int id, nul, q;
        id  = ($urandom % 10 < 7) ? DEV : (DEV + 1 + $urandom % 7) % 8;
        nul = ($urandom % 7 == 0) ? 1 : 0;
        q   = (phase == 3) ? $urandom % 2 : $urandom % 4;
        return {id[2:0], nul[0], q[1:0]};
    endfunction

    // apply the current inputs to the model: state after the next rising edge
    task automatic step();
        int wreal, rreal, prs_ok, wr, rd;
        wreal  = wown && !wnul;
        rreal  = rown && !rnul;
        prs_ok = !prs_n && wreal && rreal && (wq == rq) && (age >= 2);
        wr = wr_en && wreal && (mq[wq].size() < DEPTH) && !prs_ok;
        rd = rd_en && !oe_n && rreal && (mq[rq].size() > 0) && !prs_ok;
        tag = rd ? "R5" : "R8";
        if (wr) tag = "R4";
        if (wr_en && wreal && mq[wq].size() == DEPTH) tag = "R7";
        if (rd_en && !oe_n && rreal && mq[rq].size() == 0) tag = "R7";
        if (rd) exp_rd = mq[rq].pop_front();
        if (wr) begin
            mq[wq].push_back(int'(wr_data));
            wr_tot[wq]++;
            if (wr_tot[wq] % DEPTH == 0) tag = "R11";
        end
        if ((wr_en || rd_en) && (!wreal || !rreal)) tag = "R6";
        if (prs_ok) begin
            mq[rq].delete();
            wr_tot[rq] = 0;
            tag = "R9";
        end else if (!prs_n) begin
            tag = "R10";
        end
        if ((wr_sel || rd_sel) && !prog_done) tag = "R2";
        if (wr_sel && prog_done) begin
            if (int'(wr_addr[5:3]) == DEV) begin
                wown = 1; wnul = wr_addr[2]; wq = int'(wr_addr[1:0]);
            end else begin
                wown = 0; wnul = 0; wq = 0; tag = "R3";
            end
        end
        if (rd_sel && prog_done) begin
            if (int'(rd_addr[5:3]) == DEV) begin
                rown = 1; rnul = rd_addr[2]; rq = int'(rd_addr[1:0]);
            end else begin
                rown = 0; rnul = 0; rq = 0; tag = "R3";
            end
        end
        if ((wr_sel || rd_sel) && prog_done) age = 0;
        else if (age < 2) age++;
    endtask

    initial begin
        int phase, wp, rp;
        repeat (3) @(negedge clk);
        chk("R1", "empty in reset", int'(empty), 1);
        chk("R1", "full in reset", int'(full), 1);
        chk("R1", "almost_empty_n in reset", int'(almost_empty_n), 0);
        chk("R1", "almost_full_n in reset", int'(almost_full_n), 0);
        chk("R1", "rd_data in reset", int'(rd_data), 0);
        rst_n = 1'b1;
        tag = "R1";
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            compare();
            phase = (c / 500) % 4;
            wp = (phase == 0) ? 80 : (phase == 1) ? 20 : 50;
            rp = (phase == 0) ? 20 : (phase == 1) ? 80 : 50;
            prog_done = !((c < 40) || (c >= 1000 && c < 1040));
            wr_sel  = ($urandom % 100) < ((phase == 3) ? 4 : 6);
            rd_sel  = ($urandom % 100) < ((phase == 3) ? 4 : 6);
            wr_addr = gen_addr(phase);
            rd_addr = gen_addr(phase);
            wr_en   = ($urandom % 100) < wp;
            rd_en   = ($urandom % 100) < rp;
            oe_n    = ($urandom % 10) == 0;
            prs_n   = !(($urandom % 100) < ((phase == 3) ? 12 : 2));
            wr_data = DW'($urandom);
            step();
        end
        @(negedge clk);
        compare();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule